// File: doc/BRIEF.md
# Variable-Width Reloadable Interrupt Down-Counter

This block is a free-running interrupt timer for a processor-clocked subsystem. Software assembles a 16-bit reload value four bits at a time, issues a reload command that copies it into the counter, and then enables counting through a control register. While enabled, the counter drops by one on every clock. A width field in the same control register limits counting to the low 16, 12, 8 or 4 bits, and the bits above that span keep their value.

When the active span counts down past zero it wraps to all ones and raises a level interrupt. The interrupt stays high until software either issues a reload command or writes the control register, so both actions also acknowledge it. The present counter value is also driven out so that neighbouring logic can observe it.

Top module: `irq_divcnt`

## Requirements
- R1: A write to address i (i = 0..3) loads wr_data[3:0] into reload bits [4i+3:4i]. The other reload nybbles stay as they were, wr_data[7:4] has no effect, and the counter is not touched.
- R2: A write to address 4 copies the reload value into the counter and drops irq_o. The counter does not decrement in that cycle.
- R3: A write to address 5 sets the enable from wr_data[0] and the width select from wr_data[3:1], and drops irq_o. The counter does not decrement in that cycle.
- R4: Width select 0 makes all 16 bits active, 1 makes bits 11:0 active, 2 and 3 make bits 7:0 active, and 4 to 7 make bits 3:0 active.
- R5: While enabled, in each cycle with no write to address 4 or 5, the active span decrements by one, borrowing only inside the span. The bits above the span hold.
- R6: When the active span is all zeros, the next decrement sets it to all ones and raises irq_o.
- R7: Once raised, irq_o stays high until a write to address 4 or 5, even while counting continues.
- R8: While disabled, the counter holds its value.
- R9: Reset (rst_n low, asynchronous) clears the counter, reload value, enable, width select and irq_o. Release takes effect two clocks after rst_n rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_addr | input | 3 | Write address: 0-3 reload nybbles, 4 reload command, 5 control |
| wr_data | input | 8 | Write data |
| count_o | output | 16 | Current counter value |
| irq_o | output | 1 | Level interrupt request |

## Verification
The assertions assume that every write arrives as a single-cycle strobe with a defined address, and that addresses 6 and 7 are never written. The relations they state hold only across cycles with no reload command in flight. The stimulus issues each write for exactly one clock from the falling edge, uses only addresses 0 to 5, and leaves the bus idle between writes. As a result, every counting window has a known number of decrement cycles.

// File: rtl/irqdc_pkg.sv
`timescale 1ns/1ps
package irqdc_pkg;
  localparam int NYB_W = 4;
  localparam int SEL_W = 3;

  typedef enum logic [1:0] {
    SPAN_ALL  = 2'd0,
    SPAN_DROP1 = 2'd1,
    SPAN_DROP2 = 2'd2,
    SPAN_LOW1 = 2'd3
  } span_e;

  function automatic span_e decode_span(input logic [SEL_W-1:0] sel);
    span_e r;
    case (sel)
      3'd0:       r = SPAN_ALL;
      3'd1:       r = SPAN_DROP1;
      3'd2, 3'd3: r = SPAN_DROP2;
      default:    r = SPAN_LOW1;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/irqdc_rst_sync.sv
`timescale 1ns/1ps
module irqdc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/irqdc_regfile.sv
`timescale 1ns/1ps
module irqdc_regfile
  import irqdc_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [NYB_W-1:0]  wr_nyb,
  input  logic [SEL_W:0]    wr_ctrl,
  output logic [CNT_W-1:0]  reload_o,
  output logic              en_o,
  output logic [SEL_W-1:0]  sel_o,
  output logic              cmd_load_o,
  output logic              cmd_ctrl_o
);
  localparam int NYB_N     = CNT_W / NYB_W;
  localparam int CMD_ADDR  = NYB_N;
  localparam int CTRL_ADDR = NYB_N + 1;

  logic [NYB_W-1:0] nyb_q [NYB_N];
  logic [NYB_W-1:0] nyb_d [NYB_N];
  logic [NYB_N-1:0] nyb_we;

  for (genvar g = 0; g < NYB_N; g++) begin : g_nyb
    assign nyb_we[g] = wr_en && (wr_addr == ADDR_W'(g));

    always_comb begin
      nyb_d[g] = nyb_q[g];
      if (nyb_we[g]) nyb_d[g] = wr_nyb;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         nyb_q[g] <= '0;
      else if (nyb_we[g]) nyb_q[g] <= nyb_d[g];
    end

    assign reload_o[g*NYB_W +: NYB_W] = nyb_q[g];
  end

  assign cmd_load_o = wr_en && (wr_addr == ADDR_W'(CMD_ADDR));
  assign cmd_ctrl_o = wr_en && (wr_addr == ADDR_W'(CTRL_ADDR));

  logic             en_q, en_d;
  logic [SEL_W-1:0] sel_q, sel_d;

  always_comb begin
    en_d  = en_q;
    sel_d = sel_q;
    if (cmd_ctrl_o) begin
      en_d  = wr_ctrl[0];
      sel_d = wr_ctrl[SEL_W:1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      sel_q <= '0;
    end else if (cmd_ctrl_o) begin
      en_q  <= en_d;
      sel_q <= sel_d;
    end
  end

  assign en_o  = en_q;
  assign sel_o = sel_q;
endmodule

// File: rtl/irqdc_span.sv
`timescale 1ns/1ps
module irqdc_span
  import irqdc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic [SEL_W-1:0] sel_i,
  output logic [CNT_W-1:0] mask_o
);
  localparam int NYB_N = CNT_W / NYB_W;
  localparam int ACT_W = $clog2(NYB_N + 1);

  logic [ACT_W-1:0] act_nyb;

  always_comb begin
    case (decode_span(sel_i))
      SPAN_ALL:   act_nyb = ACT_W'(NYB_N);
      SPAN_DROP1: act_nyb = ACT_W'(NYB_N - 1);
      SPAN_DROP2: act_nyb = ACT_W'(NYB_N - 2);
      default:    act_nyb = ACT_W'(1);
    endcase
  end

  for (genvar j = 0; j < NYB_N; j++) begin : g_mask
    assign mask_o[j*NYB_W +: NYB_W] = {NYB_W{(ACT_W'(j) < act_nyb)}};
  end
endmodule

// File: rtl/irqdc_core.sv
`timescale 1ns/1ps
module irqdc_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [CNT_W-1:0] mask_i,
  input  logic [CNT_W-1:0] reload_i,
  input  logic             load_i,
  input  logic             ctrl_i,
  output logic [CNT_W-1:0] count_o,
  output logic             irq_o
);
  logic [CNT_W-1:0] count_q, count_d, stepped;
  logic             irq_q, irq_d;
  logic             wrap, step_en, count_ce, irq_ce;

  // borrow past the span is discarded by the mask; an all-zero span lands on all ones
  assign wrap     = ((count_q & mask_i) == '0);
  assign stepped  = (count_q & ~mask_i) | ((count_q - 1'b1) & mask_i);
  assign step_en  = en_i && !load_i && !ctrl_i;
  assign count_ce = load_i || step_en;
  assign irq_ce   = load_i || ctrl_i || (step_en && wrap);

  always_comb begin
    count_d = count_q;
    irq_d   = irq_q;
    if (load_i) begin
      count_d = reload_i;
      irq_d   = 1'b0;
    end else if (ctrl_i) begin
      irq_d   = 1'b0;
    end else if (step_en) begin
      count_d = stepped;
      if (wrap) irq_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        count_q <= '0;
    else if (count_ce) count_q <= count_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      irq_q <= 1'b0;
    else if (irq_ce) irq_q <= irq_d;
  end

  assign count_o = count_q;
  assign irq_o   = irq_q;
endmodule

// File: rtl/irq_divcnt.sv
`timescale 1ns/1ps
module irq_divcnt
  import irqdc_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  output logic [CNT_W-1:0]  count_o,
  output logic              irq_o
);
  logic             rst_sync_n;
  logic [CNT_W-1:0] reload_q;
  logic [CNT_W-1:0] mask_w;
  logic             en_q;
  logic [SEL_W-1:0] sel_q;
  logic             cmd_load, cmd_ctrl;
  logic             unused_hi;

  assign unused_hi = ^wr_data[7:SEL_W+1];

  irqdc_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  irqdc_regfile #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_nyb     (wr_data[NYB_W-1:0]),
    .wr_ctrl    (wr_data[SEL_W:0]),
    .reload_o   (reload_q),
    .en_o       (en_q),
    .sel_o      (sel_q),
    .cmd_load_o (cmd_load),
    .cmd_ctrl_o (cmd_ctrl)
  );

  irqdc_span #(.CNT_W(CNT_W)) u_span (
    .sel_i  (sel_q),
    .mask_o (mask_w)
  );

  irqdc_core #(.CNT_W(CNT_W)) u_core (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .en_i     (en_q),
    .mask_i   (mask_w),
    .reload_i (reload_q),
    .load_i   (cmd_load),
    .ctrl_i   (cmd_ctrl),
    .count_o  (count_o),
    .irq_o    (irq_o)
  );
endmodule

// File: rtl/irqdc_checker.sv
`timescale 1ns/1ps
module irqdc_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             load,
  input logic             ctrl,
  input logic             en,
  input logic [CNT_W-1:0] reload,
  input logic [CNT_W-1:0] mask,
  input logic [CNT_W-1:0] count,
  input logic             irq
);
  assert_reload_copy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (count == $past(reload)) && !irq);

  assert_ctrl_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl |=> !irq && $stable(count));

  assert_fixed_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ((count & ~$past(mask)) == ($past(count) & ~$past(mask))));

  assert_wrap_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> (($past(count) & $past(mask)) == '0));

  assert_irq_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !load && !ctrl) |=> irq);

  assert_disabled_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !load) |=> $stable(count));
endmodule

bind irq_divcnt irqdc_checker #(.CNT_W(CNT_W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_sync_n),
  .load   (cmd_load),
  .ctrl   (cmd_ctrl),
  .en     (en_q),
  .reload (reload_q),
  .mask   (mask_w),
  .count  (count_o),
  .irq    (irq_o)
);

// File: tb/irq_divcnt_bench.sv
`timescale 1ns/1ps
module irq_divcnt_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [15:0] count_o;
  logic        irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  irq_divcnt u_irq_divcnt (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .count_o(count_o), .irq_o(irq_o)
  );

  typedef struct packed {
    logic [2:0]  sel;
    logic [15:0] rel;
    logic [7:0]  n;
    logic [15:0] cnt;
    logic        irq;
  } vec_t;

  // width select, reload, enabled cycles, expected count, expected irq
  localparam vec_t VECS [10] = '{
    '{3'd0, 16'h0010, 8'd5,  16'h000B, 1'b0},
    '{3'd0, 16'h0002, 8'd3,  16'hFFFF, 1'b1},
    '{3'd1, 16'hA001, 8'd2,  16'hAFFF, 1'b1},
    '{3'd2, 16'h1234, 8'd53, 16'h12FF, 1'b1},
    '{3'd3, 16'h5678, 8'd16, 16'h5668, 1'b0},
    '{3'd4, 16'hBEEF, 8'd15, 16'hBEE0, 1'b0},
    '{3'd7, 16'hBEE0, 8'd17, 16'hBEEF, 1'b1},
    '{3'd5, 16'h0003, 8'd2,  16'h0001, 1'b0},
    '{3'd0, 16'h8000, 8'd1,  16'h7FFF, 1'b0},
    '{3'd1, 16'h3100, 8'd1,  16'h30FF, 1'b0}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic run_vec(input vec_t v);
    wr(3'd5, {4'h0, v.sel, 1'b0});
    for (int k = 0; k < 4; k++) wr(3'(k), {4'h0, v.rel[k*4 +: 4]});
    wr(3'd4, 8'h00);
    wr(3'd5, {4'h0, v.sel, 1'b1});
    idle(int'(v.n));
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(3);
    chk("R9 count in reset", count_o, 16'h0000);
    chk("R9 irq in reset", {15'd0, irq_o}, 16'h0000);
    rst_n = 1'b1;
    idle(3);
    idle(5);
    chk("R9/R8 enable cleared, count held", count_o, 16'h0000);
    chk("R9 irq low after release", {15'd0, irq_o}, 16'h0000);

    wr(3'd2, 8'h5A);
    chk("R1 nybble write leaves counter", count_o, 16'h0000);
    wr(3'd4, 8'h00);
    chk("R1 nybble 2 loaded, upper data ignored", count_o, 16'h0A00);
    wr(3'd0, 8'hF3);
    wr(3'd4, 8'h00);
    chk("R1 nybble 0 loaded, nybble 2 kept", count_o, 16'h0A03);

    for (int i = 0; i < 10; i++) begin
      run_vec(VECS[i]);
      chk($sformatf("R4/R5/R6 vector %0d count", i), count_o, VECS[i].cnt);
      chk($sformatf("R6 vector %0d irq", i), {15'd0, irq_o}, {15'd0, VECS[i].irq});
    end

    run_vec('{3'd0, 16'h0002, 8'd3, 16'hFFFF, 1'b1});
    idle(10);
    chk("R7 irq held while counting", {15'd0, irq_o}, 16'h0001);
    chk("R5 count after wrap", count_o, 16'hFFF5);

    wr(3'd4, 8'h00);
    chk("R2 reload copies value", count_o, 16'h0002);
    chk("R2 reload clears irq", {15'd0, irq_o}, 16'h0000);
    idle(1);
    chk("R5 decrement after reload", count_o, 16'h0001);
    idle(2);
    chk("R6 wrap full width", count_o, 16'hFFFF);
    chk("R6 irq raised", {15'd0, irq_o}, 16'h0001);

    wr(3'd5, 8'h00);
    chk("R3 control write clears irq", {15'd0, irq_o}, 16'h0000);
    chk("R3 no decrement in control cycle", count_o, 16'hFFFE);
    idle(4);
    chk("R8 disabled counter holds", count_o, 16'hFFFE);

    wr(3'd5, 8'h09);
    chk("R3 enable from bit 0", count_o, 16'hFFFE);
    idle(3);
    chk("R4 select 4 low nybble only", count_o, 16'hFFFB);

    #1 rst_n = 1'b0;
    #1;
    chk("R9 async reset clears count", count_o, 16'h0000);
    chk("R9 async reset clears irq", {15'd0, irq_o}, 16'h0000);
    idle(2);
    rst_n = 1'b1;
    idle(3);
    wr(3'd4, 8'h00);
    chk("R9 reload value cleared", count_o, 16'h0000);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule